// File: doc/BRIEF.md
# Fault Qualification and Auto-Restart Supervisor

This block sits in the digital core of a switching power controller. It watches three protection flags that arrive already synchronized from analog comparators: a thermistor under-voltage flag, a line over-voltage flag, and a current-sense over-temperature flag. The current-sense flag is only meaningful while the high-side PWM is on. Each flag passes through its own qualification rule before it can stop the converter. The thermistor flag needs a short persistence window. The line flag needs a long one, so that surges and ESD spikes pass unnoticed. The current-sense flag needs two consecutive switching cycles in which it was high.

The burst controller asks for the run or wait state through `runReq`, and the supervisor reflects this on `runOut`. Once a fault is confirmed, the supervisor latches a fault state, records which source caused it, and forces `runOut` low. It then counts out a recovery interval of about 1.5 s on a microsecond tick and raises a one-cycle restart request. A line zero-crossing pulse during the recovery interval ends the wait at once. All delays are counted on a 1 µs enable tick, and every delay is a parameter.

Top module: `prot_supervisor`

## Requirements
- R1: After reset, `runOut`, `faultActive` and `restartReq` are low and `faultCause` is 0 (no fault recorded).
- R2: Outside the fault state, `runOut` goes high on the first clock edge that samples `runReq` high while waiting, and goes low on the first edge that samples it low.
- R3: In the run state, `ntcLow` held high for `NTC_DLY_US` consecutive ticks makes the block enter the fault state on the following clock edge.
- R4: The thermistor persistence count restarts from zero whenever `ntcLow` is sampled low before it is confirmed. `ntcLow` has no effect outside the run state.
- R5: `lineOv` held high for `OV_DLY_US` ticks in any non-fault state confirms a fault. A shorter pulse has no effect.
- R6: A current-sense fault is confirmed only when `csHot` is high at `CS_CYCLES` consecutive `hsEnd` strobes in the run state. A strobe that samples `csHot` low restarts the count.
- R7: In the fault state, `runOut` is low and `faultActive` is high. `faultCause` holds the confirmed source: 1 for thermistor, 2 for line over-voltage, 3 for current-sense over-temperature.
- R8: When several sources confirm in the same cycle, the recorded cause follows the priority thermistor, then line over-voltage, then current sense.
- R9: After `RECOVER_US` ticks in the fault state, the block leaves the fault state on the next edge and pulses `restartReq` high for exactly one cycle. It then waits in the wait state.
- R10: A `lineZc` pulse sampled during the fault state ends the recovery wait on that edge, with the same one-cycle `restartReq` pulse.
- R11: While in the fault state, `runReq` has no effect: `runOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usTick | input | 1 | One-cycle enable every microsecond |
| runReq | input | 1 | Run (1) or wait (0) request from the burst controller |
| ntcLow | input | 1 | Thermistor pin below its lower threshold |
| lineOv | input | 1 | Line sense above its upper threshold |
| csHot | input | 1 | Current-sense comparator high during high-side on-time |
| hsEnd | input | 1 | Strobe once per switching cycle at the end of high-side on-time |
| lineZc | input | 1 | Line zero-crossing detected pulse |
| runOut | output | 1 | High in the run state only |
| faultActive | output | 1 | High while the fault latch is set |
| restartReq | output | 1 | One-cycle pulse when auto-recovery completes |
| faultCause | output | 2 | Source of the last confirmed fault |

## Verification
A persistence counter that fails to clear, or that counts on the wrong enable, shows at the ports as `faultActive` rising one or more cycles early or late against a cycle-exact model. A glitch-length pattern that should be ignored would instead latch a fault. A corrupted state register shows on `runOut` on the very next cycle, because its value is compared on every clock. A wrong recovery count moves the `restartReq` pulse away from the cycle that the model predicts. A priority error shows only as a wrong `faultCause` code, so the bench forces two sources to confirm in the same cycle.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } supStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic runActive;
    logic inFault;
  } ctrlStrobeT;

  // datapath -> control qualified events
  typedef struct packed {
    logic ntcHit;
    logic ovHit;
    logic csHit;
    logic recDone;
  } dpEventT;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_NTC  = 2'd1;
  localparam logic [1:0] CAUSE_OV   = 2'd2;
  localparam logic [1:0] CAUSE_CS   = 2'd3;

endpackage

// File: rtl/prot_persist.sv
module prot_persist #(
  parameter int DLY = 50,
  localparam int W = $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic tick,
  input  logic flag,
  output logic hit
);

  logic [W-1:0] cnt;
  logic         atLimit;

  assign atLimit = (cnt == W'(DLY));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!enable || !flag) begin
      cnt <= '0;
    end else if (tick && !atLimit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = enable && flag && atLimit;

  // count never passes the window length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= W'(DLY));

  // a dropped flag restarts the window
  p_drop_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flag |=> (cnt == '0));

endmodule

// File: rtl/prot_datapath.sv
module prot_datapath
  import prot_pkg::*;
#(
  parameter int NTC_DLY_US = 50,
  parameter int OV_DLY_US  = 750,
  parameter int CS_CYCLES  = 2,
  parameter int RECOVER_US = 1500000,
  localparam int CS_W  = $clog2(CS_CYCLES + 1),
  localparam int REC_W = $clog2(RECOVER_US + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       ntcLow,
  input  logic       lineOv,
  input  logic       csHot,
  input  logic       hsEnd,
  input  logic       lineZc,
  input  ctrlStrobeT strobe,
  output dpEventT    events
);

  logic ntcHit;
  logic ovHit;

  prot_persist #(.DLY(NTC_DLY_US)) uNtc (
    .clk(clk), .rstN(rstN), .enable(strobe.runActive),
    .tick(usTick), .flag(ntcLow), .hit(ntcHit)
  );

  prot_persist #(.DLY(OV_DLY_US)) uOv (
    .clk(clk), .rstN(rstN), .enable(!strobe.inFault),
    .tick(usTick), .flag(lineOv), .hit(ovHit)
  );

  // consecutive-cycle counter for current-sense over-temperature
  logic [CS_W-1:0] csCnt;
  logic            csFull;
  assign csFull = (csCnt == CS_W'(CS_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csCnt <= '0;
    end else if (!strobe.runActive) begin
      csCnt <= '0;
    end else if (hsEnd) begin
      if (!csHot)       csCnt <= '0;
      else if (!csFull) csCnt <= csCnt + 1'b1;
    end
  end

  // recovery interval counter
  logic [REC_W-1:0] recCnt;
  logic             recFull;
  assign recFull = (recCnt == REC_W'(RECOVER_US));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (!strobe.inFault) begin
      recCnt <= '0;
    end else if (usTick && !recFull) begin
      recCnt <= recCnt + 1'b1;
    end
  end

  assign events.ntcHit  = ntcHit;
  assign events.ovHit   = ovHit;
  assign events.csHit   = strobe.runActive && csFull;
  assign events.recDone = strobe.inFault && (recFull || lineZc);

  // a strobe with the comparator low restarts the cycle count
  p_cs_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runActive && hsEnd && !csHot) |=> (csCnt == '0));

  // recovery count is idle outside the fault state
  p_rec_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.inFault |=> (recCnt == '0) || strobe.inFault);

endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runReq,
  input  dpEventT    events,
  output ctrlStrobeT strobe,
  output logic       runOut,
  output logic       faultActive,
  output logic       restartReq,
  output logic [1:0] faultCause
);

  supStateT state;
  supStateT stateNxt;
  logic     anyHit;
  logic [1:0] causeSel;

  assign anyHit = events.ntcHit || events.ovHit || events.csHit;

  always_comb begin
    if (events.ntcHit)     causeSel = CAUSE_NTC;
    else if (events.ovHit) causeSel = CAUSE_OV;
    else                   causeSel = CAUSE_CS;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_FAULT: if (events.recDone) stateNxt = ST_WAIT;
      ST_RUN:   if (anyHit)         stateNxt = ST_FAULT;
                else if (!runReq)   stateNxt = ST_WAIT;
      default:  if (anyHit)         stateNxt = ST_FAULT;
                else if (runReq)    stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_WAIT;
      faultCause <= CAUSE_NONE;
      restartReq <= 1'b0;
    end else begin
      state      <= stateNxt;
      restartReq <= (state == ST_FAULT) && events.recDone;
      if (state != ST_FAULT && anyHit) faultCause <= causeSel;
    end
  end

  assign strobe.runActive = (state == ST_RUN);
  assign strobe.inFault   = (state == ST_FAULT);
  assign runOut           = (state == ST_RUN);
  assign faultActive      = (state == ST_FAULT);

  // confirmed fault always latches on the next edge
  p_fault_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!faultActive && anyHit) |=> faultActive);

  // restart pulse only follows a fault cycle that ended
  p_restart_origin_r9: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |-> ($past(faultActive) && !faultActive));

  // run request is ignored while faulted
  p_fault_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && !events.recDone) |=> (faultActive && !runOut));

  // leaving run on a dropped request
  p_run_exit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (runOut && !runReq && !anyHit) |=> !runOut);

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_pkg::*;
#(
  parameter int NTC_DLY_US = 50,
  parameter int OV_DLY_US  = 750,
  parameter int CS_CYCLES  = 2,
  parameter int RECOVER_US = 1500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       runReq,
  input  logic       ntcLow,
  input  logic       lineOv,
  input  logic       csHot,
  input  logic       hsEnd,
  input  logic       lineZc,
  output logic       runOut,
  output logic       faultActive,
  output logic       restartReq,
  output logic [1:0] faultCause
);

  ctrlStrobeT strobe;
  dpEventT    events;

  prot_datapath #(
    .NTC_DLY_US(NTC_DLY_US), .OV_DLY_US(OV_DLY_US),
    .CS_CYCLES(CS_CYCLES), .RECOVER_US(RECOVER_US)
  ) uDp (
    .clk(clk), .rstN(rstN), .usTick(usTick), .ntcLow(ntcLow),
    .lineOv(lineOv), .csHot(csHot), .hsEnd(hsEnd), .lineZc(lineZc),
    .strobe(strobe), .events(events)
  );

  prot_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .events(events),
    .strobe(strobe), .runOut(runOut), .faultActive(faultActive),
    .restartReq(restartReq), .faultCause(faultCause)
  );

endmodule

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;

  localparam int NTC = 5;
  localparam int OV  = 12;
  localparam int CSN = 2;
  localparam int REC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1, runReq = 1'b0, ntcLow = 1'b0, lineOv = 1'b0;
  logic csHot = 1'b0, hsEnd = 1'b0, lineZc = 1'b0;
  logic runOut, faultActive, restartReq;
  logic [1:0] faultCause;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  prot_supervisor #(.NTC_DLY_US(NTC), .OV_DLY_US(OV), .CS_CYCLES(CSN),
                    .RECOVER_US(REC)) u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .runReq(runReq),
    .ntcLow(ntcLow), .lineOv(lineOv), .csHot(csHot), .hsEnd(hsEnd),
    .lineZc(lineZc), .runOut(runOut), .faultActive(faultActive),
    .restartReq(restartReq), .faultCause(faultCause)
  );

  // behavioural reference: 0 wait, 1 run, 2 fault
  int mMode = 0, mNtc = 0, mOv = 0, mCs = 0, mRec = 0, mCause = 0;
  bit mRestart = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mNtc = 0; mOv = 0; mCs = 0; mRec = 0; mCause = 0; mRestart = 0;
    end else begin
      bit nh, oh, ch, done;
      nh = (mMode == 1) && ntcLow && (mNtc >= NTC);
      oh = (mMode != 2) && lineOv && (mOv >= OV);
      ch = (mMode == 1) && (mCs >= CSN);
      done = (mMode == 2) && ((mRec >= REC) || lineZc);
      mNtc = ((mMode == 1) && ntcLow) ? mNtc + ((usTick && mNtc < NTC) ? 1 : 0) : 0;
      mOv  = ((mMode != 2) && lineOv) ? mOv + ((usTick && mOv < OV) ? 1 : 0) : 0;
      if (mMode != 1) mCs = 0;
      else if (hsEnd) mCs = csHot ? ((mCs < CSN) ? mCs + 1 : mCs) : 0;
      mRec = (mMode == 2) ? mRec + ((usTick && mRec < REC) ? 1 : 0) : 0;
      mRestart = done;
      if (mMode == 2) begin
        if (done) mMode = 0;
      end else if (nh || oh || ch) begin
        mCause = nh ? 1 : (oh ? 2 : 3);
        mMode = 2;
      end else begin
        mMode = runReq ? 1 : 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 runOut", runOut, (mMode == 1) ? 1 : 0);
      chk("R7 faultActive", faultActive, (mMode == 2) ? 1 : 0);
      chk("R9 restartReq", restartReq, mRestart ? 1 : 0);
      chk("R7 faultCause", faultCause, mCause);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic recover();
    ntcLow = 0; lineOv = 0; csHot = 0; runReq = 0;
    lineZc = 1; step(1); lineZc = 0; step(2);
  endtask

  initial begin
    step(2);
    chk("R1 runOut", runOut, 0);
    chk("R1 faultActive", faultActive, 0);
    chk("R1 restartReq", restartReq, 0);
    chk("R1 faultCause", faultCause, 0);
    rstN = 1;
    step(2);

    // R2 run/wait following
    runReq = 1; step(1);
    chk("R2 enter run", runOut, 1);
    runReq = 0; step(1);
    chk("R2 leave run", runOut, 0);

    // R4 thermistor ignored in wait
    ntcLow = 1; step(NTC + 10);
    chk("R4 ntc in wait", faultActive, 0);
    ntcLow = 0;

    // R4 early drop restarts window
    runReq = 1; step(1);
    ntcLow = 1; step(NTC - 1); ntcLow = 0; step(1);
    ntcLow = 1; step(NTC - 1);
    chk("R4 no trip after restart", faultActive, 0);
    ntcLow = 0; step(1);

    // R3 full window then latch on the following edge
    ntcLow = 1; step(NTC);
    chk("R3 not yet", faultActive, 0);
    step(1);
    chk("R3 fault", faultActive, 1);
    chk("R7 cause ntc", faultCause, 1);
    chk("R7 run low", runOut, 0);

    // R11 run request ignored while faulted; R9 timed recovery
    ntcLow = 0; runReq = 1;
    step(REC - 1);
    chk("R11 still faulted", faultActive, 1);
    chk("R11 run held low", runOut, 0);
    step(1);
    chk("R9 no pulse yet", restartReq, 0);
    step(1);
    chk("R9 fault cleared", faultActive, 0);
    chk("R9 restart pulse", restartReq, 1);
    step(1);
    chk("R9 pulse one cycle", restartReq, 0);
    chk("R2 run after restart", runOut, 1);

    // R5 short line surge ignored, long one trips in wait
    runReq = 0; step(1);
    lineOv = 1; step(OV - 1); lineOv = 0; step(1);
    chk("R5 short surge", faultActive, 0);
    lineOv = 1; step(OV + 1);
    chk("R5 ov fault", faultActive, 1);
    chk("R7 cause ov", faultCause, 2);
    lineOv = 0;

    // R10 zero-crossing cuts recovery short
    step(3);
    lineZc = 1; step(1); lineZc = 0;
    chk("R10 early exit", faultActive, 0);
    chk("R10 restart pulse", restartReq, 1);
    step(1);

    // R6 non-consecutive hot strobes do not trip
    runReq = 1; step(1);
    csHot = 1; hsEnd = 1; step(1); hsEnd = 0; step(2);
    csHot = 0; hsEnd = 1; step(1); hsEnd = 0;
    csHot = 1; hsEnd = 1; step(1); hsEnd = 0; step(3);
    chk("R6 broken run", faultActive, 0);
    hsEnd = 1; step(1); hsEnd = 0;
    chk("R6 not yet", faultActive, 0);
    step(1);
    chk("R6 cs fault", faultActive, 1);
    chk("R7 cause cs", faultCause, 3);
    recover();

    // R8 thermistor and line confirm together: thermistor wins
    runReq = 1; step(1);
    lineOv = 1; step(OV - NTC);
    ntcLow = 1; step(NTC);
    chk("R8 not yet", faultActive, 0);
    step(1);
    chk("R8 fault", faultActive, 1);
    chk("R8 priority", faultCause, 1);
    recover();

    // R3 with sparse ticks: window counts ticks, not clocks
    runReq = 1; step(1);
    ntcLow = 1;
    for (int i = 0; i < 3 * NTC; i++) begin
      usTick = (i % 3 == 0); step(1);
    end
    usTick = 1; step(1);
    chk("R3 sparse tick fault", faultActive, 1);
    recover();

    step(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule